// File: doc/BRIEF.md
# Framed Codec Power and Master-Clock Mode Controller

This block decides whether a framed voice codec is powered and how its clocks are arranged, using only what it can see on a handful of slow control pins. Two of those pins are dual-use: one carries either a receive master clock or a static power-down level, the other carries either a receive bit clock or a static rate-select level. The controller samples every pin in a free-running system clock domain, classifies each dual-use pin as toggling, static, or not yet known, and watches both frame sync inputs for rising edges.

From that it derives a power state (powered down at reset, woken by the first frame sync, dropped again by a forcing pin level or by a long silence on both frame syncs). It also derives a transmit-output enable that opens only on the second transmit frame sync after wake-up, the master-clock source for the receive side, and the divider ratio for the frame timing generator. The ratio follows a static rate-select level, or the clocked-pin default of the chosen companding variant. Where the 1.5 MHz family applies, it follows a per-frame count of transmit master-clock edges, so that a 193-clock frame is told apart from a 192-clock frame.

Top module: `codec_pm_ctrl`

## Requirements
- R1: While reset is asserted and after its release, `powered_up` and `tx_out_en` are 0 until a wake condition occurs.
- R2: While the power-down pin is classified static high, the block is powered down within one cycle of that classification and ignores all frame sync pulses.
- R3: `mclk_sel_rx` is 1 (receive master clock) while the power-down pin is classified toggling, and 0 (transmit master clock) while it is classified static at either level.
- R4: When the power-down pin is static low or toggling, a rising edge on either frame sync powers the block up.
- R5: Once powered, the block powers down `TIMEOUT_CLKS` system clocks after the last rising edge on either frame sync; every such edge restarts the count.
- R6: After wake-up, `tx_out_en` becomes 1 only on the second transmit frame sync rising edge counted from wake-up, including the waking edge if it was a transmit one. Receive frame syncs do not count.
- R7: `div_sel` encoding is 0 for a 256-clock frame (2.048 MHz), 1 for 192 (1.536 MHz) and 2 for 193 (1.544 MHz). With `LAW_A`=0, a rate pin held static low selects the 1.5 MHz family and static high selects 0. With `LAW_A`=1 the mapping is reversed.
- R8: While the rate pin is toggling or unclassified, `rx_bclk_sep` is 1 only if it is toggling. The family used is the clocked default: 1.5 MHz when `LAW_A`=0, 2.048 MHz when `LAW_A`=1.
- R9: Within the 1.5 MHz family, `div_sel` is 2 if the last complete transmit frame held exactly `FRAME_MCLKS`+1 transmit master-clock rising edges, and 1 otherwise.
- R10: A dual-use pin is classified static after `STATIC_WINS` consecutive windows of `WIN_CLKS` system clocks with no edge. It is classified toggling after two edges. A single edge after static clears both classifications, and a toggling classification persists until static is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_mclk | input | 1 | Transmit master clock (sampled) |
| rx_mclk_pd | input | 1 | Receive master clock or static power-down level |
| rx_bclk_sel | input | 1 | Receive bit clock or static rate-select level |
| tx_fsync | input | 1 | Transmit frame sync |
| rx_fsync | input | 1 | Receive frame sync |
| powered_up | output | 1 | Block is in a powered state |
| tx_out_en | output | 1 | Transmit data output may be driven |
| mclk_sel_rx | output | 1 | 1: receive side uses receive master clock; 0: transmit master clock |
| rx_bclk_sep | output | 1 | Separate receive bit clock in use |
| div_sel | output | 2 | Frame divider select (0: 256, 1: 192, 2: 193) |

## Verification
The hardest situation to reach is the hand-over of the power-down pin from toggling to static. During this interval the pin has stopped moving, but the toggling classification must persist for the full idle window before the source select falls back. The stimulus runs the pin as a clock, powers the block through a receive sync, then freezes the pin low. It samples the source select once inside the idle window and once after it. The 193-clock frame detection is reached by spacing transmit syncs exactly 193 master-clock periods apart for several frames, then returning to 192-period spacing.

// File: rtl/codec_pm_pkg.sv
// Shared types for the codec power and clock-mode controller.
package codec_pm_pkg;

    // Frame divider selection driven to the frame timing generator.
    typedef enum logic [1:0] {
        DIV_256 = 2'd0,
        DIV_192 = 2'd1,
        DIV_193 = 2'd2
    } div_sel_e;

    // Power sequencing states; UP0/UP1 count transmit syncs since wake.
    typedef enum logic [1:0] {
        PWR_DOWN = 2'd0,
        PWR_UP0  = 2'd1,
        PWR_UP1  = 2'd2,
        PWR_LIVE = 2'd3
    } pwr_state_e;

endpackage

// File: rtl/codec_sync.sv
// Multi-bit input synchronizer.
// Assumes: each bit is an independent asynchronous level; no bus coherence.
module codec_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic [STAGES-1:0] sh;
            // Shift the asynchronous input through the flop chain.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh <= '0;
                else        sh <= {sh[STAGES-2:0], din[i]};
            end
            assign lvl[i] = sh[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/codec_pin_activity.sv
// Classifies a dual-use pin as toggling, static or unknown.
// Assumes: WIN_CLKS system clocks span one expected clock period on the pin;
// static needs STATIC_WINS edge-free windows, toggling needs two edges.
module codec_pin_activity #(
    parameter int WIN_CLKS    = 4,
    parameter int STATIC_WINS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic is_static,
    output logic is_toggling,
    output logic level
);
    localparam int WW = (WIN_CLKS > 1) ? $clog2(WIN_CLKS) : 1;
    localparam int IW = $clog2(STATIC_WINS + 1);

    logic          s_lvl;
    logic          prev;
    logic          edge_seen;
    logic [WW-1:0] win_cnt;
    logic [IW-1:0] idle_wins;
    logic          one_edge;

    codec_sync #(.W(1), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin),
        .lvl   (s_lvl)
    );

    // Remember the last synchronized level for edge detection.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= s_lvl;
    end

    assign edge_seen = s_lvl ^ prev;
    assign level     = s_lvl;

    // Count edge-free windows and edges; settle the classification.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt     <= '0;
            idle_wins   <= '0;
            one_edge    <= 1'b0;
            is_static   <= 1'b0;
            is_toggling <= 1'b0;
        end else if (edge_seen) begin
            win_cnt   <= '0;
            idle_wins <= '0;
            is_static <= 1'b0;
            if (one_edge) is_toggling <= 1'b1;
            one_edge  <= 1'b1;
        end else if (win_cnt == WW'(WIN_CLKS - 1)) begin
            win_cnt <= '0;
            if (idle_wins == IW'(STATIC_WINS - 1)) begin
                is_static   <= 1'b1;
                is_toggling <= 1'b0;
                one_edge    <= 1'b0;
            end else begin
                idle_wins <= idle_wins + 1'b1;
            end
        end else begin
            win_cnt <= win_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/codec_rate_sel.sv
// Chooses the frame divider from the rate pin and a per-frame count of
// transmit master-clock edges.
// Assumes: mclk_rise and frame_rise come through equal synchronizer depth.
module codec_rate_sel
    import codec_pm_pkg::*;
#(
    parameter bit LAW_A       = 1'b0,
    parameter int FRAME_MCLKS = 192
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     mclk_rise,
    input  logic     frame_rise,
    input  logic     sel_static,
    input  logic     sel_toggling,
    input  logic     sel_level,
    output div_sel_e div_sel,
    output logic     rx_bclk_sep
);
    localparam int  CW      = $clog2(2 * FRAME_MCLKS + 2);
    localparam int  CMAX    = (1 << CW) - 1;
    localparam int  LONG_FR = FRAME_MCLKS + 1;
    localparam logic FAM_CLOCKED = !LAW_A;

    logic [CW-1:0] mclk_cnt;
    logic          long_frame;
    logic          fam_15;

    // Count master-clock edges per frame; judge the frame at each sync.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mclk_cnt   <= '0;
            long_frame <= 1'b0;
        end else if (frame_rise) begin
            long_frame <= (mclk_cnt == CW'(LONG_FR));
            mclk_cnt   <= CW'(mclk_rise);
        end else if (mclk_rise && mclk_cnt != CW'(CMAX)) begin
            mclk_cnt <= mclk_cnt + 1'b1;
        end
    end

    // Pick the clock family from the static level or the clocked default.
    always_comb begin
        if (sel_static) fam_15 = sel_level ^ !LAW_A;
        else            fam_15 = FAM_CLOCKED;
    end

    // Map family and measured frame length to the divider select.
    always_comb begin
        if (!fam_15)         div_sel = DIV_256;
        else if (long_frame) div_sel = DIV_193;
        else                 div_sel = DIV_192;
    end

    assign rx_bclk_sep = sel_toggling;
endmodule

// File: rtl/codec_pwr_fsm.sv
// Power sequencing: wake on a frame sync, sleep on force or sync silence,
// and open the transmit output on the second transmit sync after wake.
// Assumes: rise inputs are one-cycle pulses in the system clock domain.
module codec_pwr_fsm
    import codec_pm_pkg::*;
#(
    parameter int TIMEOUT_CLKS = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_rise,
    input  logic rx_rise,
    input  logic wake_ok,
    input  logic force_pd,
    output logic powered_up,
    output logic tx_out_en,
    output logic timeout_hit
);
    localparam int TW = $clog2(TIMEOUT_CLKS + 1);

    pwr_state_e    state;
    logic [TW-1:0] idle_cnt;
    logic          any_rise;

    assign any_rise    = tx_rise | rx_rise;
    assign timeout_hit = (state != PWR_DOWN) && !any_rise
                         && (idle_cnt == TW'(TIMEOUT_CLKS - 1));

    // Sync-silence counter, restarted by any frame sync edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  idle_cnt <= '0;
        else if (any_rise || state == PWR_DOWN)      idle_cnt <= '0;
        else if (idle_cnt != TW'(TIMEOUT_CLKS - 1))  idle_cnt <= idle_cnt + 1'b1;
    end

    // Power state transitions.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PWR_DOWN;
        end else if (force_pd || timeout_hit) begin
            state <= PWR_DOWN;
        end else begin
            case (state)
                PWR_DOWN: if (wake_ok && any_rise) state <= tx_rise ? PWR_UP1 : PWR_UP0;
                PWR_UP0:  if (tx_rise) state <= PWR_UP1;
                PWR_UP1:  if (tx_rise) state <= PWR_LIVE;
                default:  state <= state;
            endcase
        end
    end

    assign powered_up = (state != PWR_DOWN);
    assign tx_out_en  = (state == PWR_LIVE);
endmodule

// File: rtl/codec_pm_ctrl.sv
// Top of the codec power and clock-mode controller.
// Assumes: all pins are asynchronous to clk and slower than clk/2.
module codec_pm_ctrl
    import codec_pm_pkg::*;
#(
    parameter bit LAW_A        = 1'b0,
    parameter int WIN_CLKS     = 4,
    parameter int STATIC_WINS  = 16,
    parameter int TIMEOUT_CLKS = 100000,
    parameter int FRAME_MCLKS  = 192
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_mclk,
    input  logic       rx_mclk_pd,
    input  logic       rx_bclk_sel,
    input  logic       tx_fsync,
    input  logic       rx_fsync,
    output logic       powered_up,
    output logic       tx_out_en,
    output logic       mclk_sel_rx,
    output logic       rx_bclk_sep,
    output logic [1:0] div_sel
);
    localparam int NS = 3;

    logic [NS-1:0] s_lvl, s_prev, s_rise;
    logic pd_static, pd_toggling, pd_level;
    logic rs_static, rs_toggling, rs_level;
    logic force_pd, wake_ok, timeout_hit;
    logic tx_fs_rise, rx_fs_rise, mclk_rise;
    div_sel_e div_e;

    codec_sync #(.W(NS), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({tx_mclk, rx_fsync, tx_fsync}),
        .lvl   (s_lvl)
    );

    // Previous synchronized levels for rising-edge pulses.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_prev <= '0;
        else        s_prev <= s_lvl;
    end

    assign s_rise     = s_lvl & ~s_prev;
    assign tx_fs_rise = s_rise[0];
    assign rx_fs_rise = s_rise[1];
    assign mclk_rise  = s_rise[2];

    codec_pin_activity #(.WIN_CLKS(WIN_CLKS), .STATIC_WINS(STATIC_WINS)) u_pd_act (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin         (rx_mclk_pd),
        .is_static   (pd_static),
        .is_toggling (pd_toggling),
        .level       (pd_level)
    );

    codec_pin_activity #(.WIN_CLKS(WIN_CLKS), .STATIC_WINS(STATIC_WINS)) u_rs_act (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin         (rx_bclk_sel),
        .is_static   (rs_static),
        .is_toggling (rs_toggling),
        .level       (rs_level)
    );

    assign force_pd    = pd_static & pd_level;
    assign wake_ok     = pd_toggling | (pd_static & ~pd_level);
    assign mclk_sel_rx = pd_toggling;

    codec_pwr_fsm #(.TIMEOUT_CLKS(TIMEOUT_CLKS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_rise     (tx_fs_rise),
        .rx_rise     (rx_fs_rise),
        .wake_ok     (wake_ok),
        .force_pd    (force_pd),
        .powered_up  (powered_up),
        .tx_out_en   (tx_out_en),
        .timeout_hit (timeout_hit)
    );

    codec_rate_sel #(.LAW_A(LAW_A), .FRAME_MCLKS(FRAME_MCLKS)) u_rate (
        .clk          (clk),
        .rst_n        (rst_n),
        .mclk_rise    (mclk_rise),
        .frame_rise   (tx_fs_rise),
        .sel_static   (rs_static),
        .sel_toggling (rs_toggling),
        .sel_level    (rs_level),
        .div_sel      (div_e),
        .rx_bclk_sep  (rx_bclk_sep)
    );

    assign div_sel = div_e;
endmodule

// File: rtl/codec_pm_ctrl_chk.sv
// Property checker for codec_pm_ctrl, attached by bind.
module codec_pm_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic powered_up,
    input logic tx_out_en,
    input logic force_pd,
    input logic timeout_hit,
    input logic tx_fs_rise,
    input logic rx_fs_rise,
    input logic pd_static,
    input logic pd_toggling
);
    // R2: a forcing level leaves the block down on the next cycle.
    p_forced_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        force_pd |=> !powered_up);

    // R4: power-up only follows a frame sync edge.
    p_wake_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(powered_up) |-> $past(tx_fs_rise || rx_fs_rise));

    // R5: power-down only follows a force or a silence timeout.
    p_down_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(powered_up) |-> $past(force_pd || timeout_hit));

    // R6: the transmit output is never enabled while powered down.
    p_txen_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_out_en |-> powered_up);

    // R6: the transmit output opens only on a transmit sync edge.
    p_txen_on_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_out_en) |-> $past(tx_fs_rise));

    // R10: a pin is never both static and toggling.
    p_class_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pd_static, pd_toggling}));
endmodule

bind codec_pm_ctrl codec_pm_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .powered_up  (powered_up),
    .tx_out_en   (tx_out_en),
    .force_pd    (force_pd),
    .timeout_hit (timeout_hit),
    .tx_fs_rise  (tx_fs_rise),
    .rx_fs_rise  (rx_fs_rise),
    .pd_static   (pd_static),
    .pd_toggling (pd_toggling)
);

// File: tb/codec_pm_ctrl_test.sv
// Directed bench for codec_pm_ctrl.
module codec_pm_ctrl_test;
    localparam int TOUT = 2000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_mclk = 1'b0;
    logic rx_mclk_pd = 1'b0;
    logic rx_bclk_sel = 1'b0;
    logic tx_fsync = 1'b0;
    logic rx_fsync = 1'b0;
    logic powered_up, tx_out_en, mclk_sel_rx, rx_bclk_sep;
    logic [1:0] div_sel;

    int pd_mode = 0;  // 0 static low, 1 static high, 2 toggling
    int rs_mode = 0;
    int checks = 0;
    int failures = 0;

    codec_pm_ctrl #(
        .LAW_A(1'b0), .WIN_CLKS(4), .STATIC_WINS(16),
        .TIMEOUT_CLKS(TOUT), .FRAME_MCLKS(192)
    ) uut (
        .clk(clk), .rst_n(rst_n), .tx_mclk(tx_mclk), .rx_mclk_pd(rx_mclk_pd),
        .rx_bclk_sel(rx_bclk_sel), .tx_fsync(tx_fsync), .rx_fsync(rx_fsync),
        .powered_up(powered_up), .tx_out_en(tx_out_en), .mclk_sel_rx(mclk_sel_rx),
        .rx_bclk_sep(rx_bclk_sep), .div_sel(div_sel)
    );

    always #5 clk = ~clk;
    always #20 tx_mclk = ~tx_mclk;
    always #20 begin
        if (pd_mode == 2) rx_mclk_pd = ~rx_mclk_pd;
        else              rx_mclk_pd = (pd_mode == 1);
    end
    always #30 begin
        if (rs_mode == 2) rx_bclk_sel = ~rx_bclk_sel;
        else              rx_bclk_sel = (rs_mode == 1);
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tx();
        tx_fsync = 1'b1; wait_n(3); tx_fsync = 1'b0; wait_n(8);
    endtask

    task automatic pulse_rx();
        rx_fsync = 1'b1; wait_n(3); rx_fsync = 1'b0; wait_n(8);
    endtask

    task automatic tx_frames(input int n, input int len);
        for (int i = 0; i < n; i++) begin
            tx_fsync = 1'b1; wait_n(3); tx_fsync = 1'b0; wait_n(len - 3);
        end
    endtask

    task automatic t_reset();
        chk("R1 powered in reset", powered_up, 0);
        chk("R1 txen in reset", tx_out_en, 0);
        rst_n = 1'b1;
        wait_n(100);
        chk("R1 powered after reset", powered_up, 0);
        chk("R3 static low selects tx mclk", mclk_sel_rx, 0);
    endtask

    task automatic t_wake_tx();
        pulse_tx();
        chk("R4 wake by tx sync", powered_up, 1);
        chk("R6 txen after first tx", tx_out_en, 0);
        pulse_rx();
        chk("R6 rx sync does not open tx", tx_out_en, 0);
        pulse_tx();
        chk("R6 txen after second tx", tx_out_en, 1);
    endtask

    task automatic t_timeout();
        pulse_rx();
        wait_n(TOUT - 60);
        chk("R5 still up before timeout", powered_up, 1);
        wait_n(110);
        chk("R5 down after timeout", powered_up, 0);
        chk("R5 txen cleared", tx_out_en, 0);
    endtask

    task automatic t_wake_rx();
        pulse_rx();
        chk("R4 wake by rx sync", powered_up, 1);
        pulse_tx();
        chk("R6 one tx after rx wake", tx_out_en, 0);
        pulse_tx();
        chk("R6 two tx after rx wake", tx_out_en, 1);
    endtask

    task automatic t_force();
        pd_mode = 1;
        wait_n(100);
        chk("R2 static high forces down", powered_up, 0);
        chk("R3 static high selects tx mclk", mclk_sel_rx, 0);
        pulse_tx();
        pulse_rx();
        chk("R2 syncs ignored while forced", powered_up, 0);
    endtask

    task automatic t_toggle();
        pd_mode = 2;
        wait_n(20);
        chk("R3 toggling selects rx mclk", mclk_sel_rx, 1);
        pulse_rx();
        chk("R4 wake with toggling pin", powered_up, 1);
        pd_mode = 0;
        wait_n(40);
        chk("R10 toggling held inside idle window", mclk_sel_rx, 1);
        wait_n(50);
        chk("R10 static after idle windows", mclk_sel_rx, 0);
        chk("R4 stays up on static low", powered_up, 1);
    endtask

    task automatic t_rate();
        rs_mode = 0;
        tx_frames(3, 768);
        chk("R9 192-clock frame", div_sel, 1);
        chk("R7 static low sep off", rx_bclk_sep, 0);
        tx_frames(3, 772);
        chk("R9 193-clock frame", div_sel, 2);
        rs_mode = 1;
        wait_n(100);
        chk("R7 static high selects 256", div_sel, 0);
        rs_mode = 2;
        wait_n(20);
        chk("R8 toggling rate pin sep", rx_bclk_sep, 1);
        chk("R8 clocked default family", div_sel, 2);
        rs_mode = 0;
        wait_n(100);
        tx_frames(3, 768);
        chk("R9 back to 192-clock frame", div_sel, 1);
        chk("R7 static low sep cleared", rx_bclk_sep, 0);
    endtask

    initial begin
        wait_n(5);
        t_reset();
        t_wake_tx();
        t_timeout();
        t_wake_rx();
        t_force();
        t_toggle();
        t_rate();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule